// File: doc/BRIEF.md
# Indirect PHY Register Access Controller

This block moves a 16-bit value to or from one of the 32 registers of an external PHY. The PHY is not reached directly: it sits behind a small group of byte-wide management registers on a generic register-access port. A host pulses `start` with a 5-bit PHY register number, a direction flag and, for writes, a 16-bit value. The controller then runs a fixed sequence of byte accesses on the register port. It stores the PHY register number. For a write, it loads the two data bytes, and storing the upper byte launches the transfer. For a read, it sets a read-command bit.

The controller then watches the management status register. When the status shows busy, it waits a host-chosen number of idle cycles and reads the status again. It gives up after a fixed number of busy readings. A successful read clears the command register, fetches both result bytes and joins them into one word. Every operation ends with a one-cycle `done` pulse. `err` is raised in the same cycle when the busy limit was hit.

The register port uses a request/done handshake. `reg_req` stays high, with address, direction and write data held steady, until the cycle in which `reg_done` is high. Read data on `reg_rdata` is taken in that same cycle. The next access may start in the following cycle.

Top module: `phy_ind_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `reg_req` are low and `rdata` is zero.
- R2: A write operation performs exactly these register writes, in this order, before polling:
  - the PHY register number, zero-extended, to address 0x14;
  - the low data byte to 0x16;
  - the high data byte to 0x17.
- R3: A read operation first writes the PHY register number to 0x14. It then writes 0x01 to the command register at 0x12, where bit 0 is the read command. No value other than 0x00 or 0x01 is ever written to 0x12.
- R4: After launching an operation, the controller reads the status register at 0x0A. It treats the operation as finished when a status read returns bit 0 (busy) low. All other status bits are ignored.
- R5: After each status read that returns busy, `reg_req` stays low for exactly `poll_gap`+1 cycles before the next status read is requested.
- R6: If 15 successive status reads all return busy, the operation ends with `err` high and no further register access. A read that ends this way returns `rdata` = 0.
- R7: A successful read proceeds in three steps after the non-busy status: it writes 0x00 to 0x12, then reads 0x18 (low byte), then reads 0x19 (high byte). It returns `rdata` = {byte from 0x19, byte from 0x18}. A write returns `rdata` = 0.
- R8: Each operation produces exactly one `done` pulse, one cycle long. `err` is high only in that cycle, and only when the operation timed out.
- R9: A `start` pulse while `busy` is high is ignored: it alters neither the running sequence nor its result.
- R10: While `reg_req` is high and `reg_done` is low, `reg_req`, `reg_we`, `reg_addr` and `reg_wdata` keep their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| wr | input | 1 | 1 = PHY write, 0 = PHY read |
| phy_reg | input | 5 | PHY register number |
| wdata | input | 16 | Value to write to the PHY register |
| poll_gap | input | 8 | Idle cycles minus one between busy polls |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Timeout flag, valid with `done` |
| rdata | output | 16 | PHY read result, updated at completion |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | 1 = register write, 0 = register read |
| reg_addr | output | 8 | Management register address |
| reg_wdata | output | 8 | Register write byte |
| reg_rdata | input | 8 | Register read byte, valid with `reg_done` |
| reg_done | input | 1 | Access complete |

## Verification
The assertions check, on every cycle, the properties that hold regardless of the operation:
- the request stays stable until the handshake completes;
- `done` is a single-cycle pulse, and `err` appears only alongside it;
- the bus stays silent while idle;
- status polls are reads, and only the two legal values reach the command register;
- a timeout never reports data.

Only the bench scenarios can show the whole access order of an operation, the exact idle time between polls, the 15-poll limit with its edge at 14 and 15 busy readings, the result byte order, and that a mid-operation `start` leaves the sequence untouched. To do so, the bench sweeps the direction, the busy count, the gap and the responder latency.

// File: rtl/piac_pkg.sv
package piac_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WLO,
    ST_WHI,
    ST_CMD,
    ST_POLL,
    ST_GAP,
    ST_CLR,
    ST_RLO,
    ST_RHI,
    ST_FIN
  } piac_state_e;
endpackage

// File: rtl/piac_access_map.sv
module piac_access_map
  import piac_pkg::*;
#(
  parameter int                PHY_AW   = 5,
  parameter int                REG_AW   = 8,
  parameter logic [REG_AW-1:0] A_PHYADR = 8'h14,
  parameter logic [REG_AW-1:0] A_WDL    = 8'h16,
  parameter logic [REG_AW-1:0] A_CMD    = 8'h12,
  parameter logic [REG_AW-1:0] A_STAT   = 8'h0A,
  parameter logic [REG_AW-1:0] A_RDL    = 8'h18,
  parameter logic [REG_AW-1:0] A_RDH    = 8'h19,
  parameter int                RD_BIT   = 0
) (
  input  piac_state_e         st,
  input  logic [PHY_AW-1:0]   phy_reg,
  input  logic [2*BYTE_W-1:0] wdata,
  output logic                acc,
  output logic                we,
  output logic [REG_AW-1:0]   addr,
  output logic [BYTE_W-1:0]   data
);
  localparam logic [REG_AW-1:0] A_WDH   = A_WDL + REG_AW'(1);
  localparam logic [BYTE_W-1:0] RD_MASK = BYTE_W'(1) << RD_BIT;

  always_comb begin
    acc  = 1'b1;
    we   = 1'b1;
    addr = '0;
    data = '0;
    case (st)
      ST_ADDR: begin addr = A_PHYADR; data = BYTE_W'(phy_reg); end
      ST_WLO:  begin addr = A_WDL;    data = wdata[BYTE_W-1:0]; end
      ST_WHI:  begin addr = A_WDH;    data = wdata[2*BYTE_W-1:BYTE_W]; end
      ST_CMD:  begin addr = A_CMD;    data = RD_MASK; end
      ST_POLL: begin addr = A_STAT;   we = 1'b0; end
      ST_CLR:  begin addr = A_CMD;    data = '0; end
      ST_RLO:  begin addr = A_RDL;    we = 1'b0; end
      ST_RHI:  begin addr = A_RDH;    we = 1'b0; end
      default: begin acc = 1'b0;      we = 1'b0; end
    endcase
  end
endmodule

// File: rtl/piac_poll_timer.sv
module piac_poll_timer #(
  parameter int MAX_POLLS = 15,
  parameter int GAP_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             poll_busy,
  input  logic             gap_run,
  input  logic [GAP_W-1:0] gap_len,
  output logic             last_try,
  output logic             gap_done
);
  localparam int CNT_W = $clog2(MAX_POLLS + 1);

  logic [CNT_W-1:0] att_q;
  logic [GAP_W-1:0] gcnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      att_q  <= '0;
      gcnt_q <= '0;
    end else begin
      if (arm)            att_q <= '0;
      else if (poll_busy) att_q <= att_q + CNT_W'(1);

      if (poll_busy)                    gcnt_q <= gap_len;
      else if (gap_run && gcnt_q != '0) gcnt_q <= gcnt_q - GAP_W'(1);
    end
  end

  assign last_try = (att_q == CNT_W'(MAX_POLLS - 1));
  assign gap_done = (gcnt_q == '0);
endmodule

// File: rtl/piac_rd_asm.sv
module piac_rd_asm
  import piac_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                lo_cap,
  input  logic                hi_cap,
  input  logic [BYTE_W-1:0]   byte_in,
  output logic [2*BYTE_W-1:0] word
);
  logic [BYTE_W-1:0] lo_q, hi_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (lo_cap) lo_q <= byte_in;
      if (hi_cap) hi_q <= byte_in;
    end
  end

  assign word = {hi_q, lo_q};
endmodule

// File: rtl/phy_ind_ctrl.sv
module phy_ind_ctrl
  import piac_pkg::*;
#(
  parameter int                PHY_AW    = 5,
  parameter int                REG_AW    = 8,
  parameter int                GAP_W     = 8,
  parameter int                MAX_POLLS = 15,
  parameter logic [REG_AW-1:0] A_PHYADR  = 8'h14,
  parameter logic [REG_AW-1:0] A_WDL     = 8'h16,
  parameter logic [REG_AW-1:0] A_CMD     = 8'h12,
  parameter logic [REG_AW-1:0] A_STAT    = 8'h0A,
  parameter logic [REG_AW-1:0] A_RDL     = 8'h18,
  parameter logic [REG_AW-1:0] A_RDH     = 8'h19,
  parameter int                RD_BIT    = 0,
  parameter int                BUSY_BIT  = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                wr,
  input  logic [PHY_AW-1:0]   phy_reg,
  input  logic [2*BYTE_W-1:0] wdata,
  input  logic [GAP_W-1:0]    poll_gap,
  output logic                busy,
  output logic                done,
  output logic                err,
  output logic [2*BYTE_W-1:0] rdata,
  output logic                reg_req,
  output logic                reg_we,
  output logic [REG_AW-1:0]   reg_addr,
  output logic [BYTE_W-1:0]   reg_wdata,
  input  logic [BYTE_W-1:0]   reg_rdata,
  input  logic                reg_done
);
  localparam int WORD_W = 2 * BYTE_W;

  piac_state_e         state_q, nxt;
  logic                op_wr_q, tout_q;
  logic [PHY_AW-1:0]   op_reg_q;
  logic [WORD_W-1:0]   op_wd_q;
  logic [GAP_W-1:0]    op_gap_q;

  logic                launch;
  logic                poll_done, poll_busy, last_try, gap_done;
  logic                sel_wr;
  logic [PHY_AW-1:0]   sel_reg;
  logic [WORD_W-1:0]   sel_wd;
  logic                acc_n, we_n;
  logic [REG_AW-1:0]   addr_n;
  logic [BYTE_W-1:0]   data_n;
  logic [WORD_W-1:0]   rd_word;

  assign launch    = (state_q == ST_IDLE) && start;
  assign poll_done = (state_q == ST_POLL) && reg_done;
  assign poll_busy = poll_done && reg_rdata[BUSY_BIT];

  // Operation fields: live inputs in the launch cycle, latched copies afterwards.
  assign sel_wr  = (state_q == ST_IDLE) ? wr      : op_wr_q;
  assign sel_reg = (state_q == ST_IDLE) ? phy_reg : op_reg_q;
  assign sel_wd  = (state_q == ST_IDLE) ? wdata   : op_wd_q;

  always_comb begin
    nxt = state_q;
    case (state_q)
      ST_IDLE: if (start)    nxt = ST_ADDR;
      ST_ADDR: if (reg_done) nxt = op_wr_q ? ST_WLO : ST_CMD;
      ST_WLO:  if (reg_done) nxt = ST_WHI;
      ST_WHI:  if (reg_done) nxt = ST_POLL;
      ST_CMD:  if (reg_done) nxt = ST_POLL;
      ST_POLL: begin
        if (reg_done) begin
          if (!reg_rdata[BUSY_BIT]) nxt = op_wr_q ? ST_FIN : ST_CLR;
          else if (last_try)        nxt = ST_FIN;
          else                      nxt = ST_GAP;
        end
      end
      ST_GAP:  if (gap_done) nxt = ST_POLL;
      ST_CLR:  if (reg_done) nxt = ST_RLO;
      ST_RLO:  if (reg_done) nxt = ST_RHI;
      ST_RHI:  if (reg_done) nxt = ST_FIN;
      ST_FIN:  nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  piac_access_map #(
    .PHY_AW(PHY_AW), .REG_AW(REG_AW), .A_PHYADR(A_PHYADR), .A_WDL(A_WDL),
    .A_CMD(A_CMD), .A_STAT(A_STAT), .A_RDL(A_RDL), .A_RDH(A_RDH), .RD_BIT(RD_BIT)
  ) u_map (
    .st(nxt), .phy_reg(sel_reg), .wdata(sel_wd),
    .acc(acc_n), .we(we_n), .addr(addr_n), .data(data_n)
  );

  piac_poll_timer #(.MAX_POLLS(MAX_POLLS), .GAP_W(GAP_W)) u_timer (
    .clk(clk), .rst(rst), .arm(launch), .poll_busy(poll_busy),
    .gap_run(state_q == ST_GAP), .gap_len(op_gap_q),
    .last_try(last_try), .gap_done(gap_done)
  );

  piac_rd_asm u_asm (
    .clk(clk), .rst(rst), .clr(launch),
    .lo_cap((state_q == ST_RLO) && reg_done),
    .hi_cap((state_q == ST_RHI) && reg_done),
    .byte_in(reg_rdata), .word(rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      op_wr_q   <= 1'b0;
      op_reg_q  <= '0;
      op_wd_q   <= '0;
      op_gap_q  <= '0;
      tout_q    <= 1'b0;
      reg_req   <= 1'b0;
      reg_we    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
      rdata     <= '0;
    end else begin
      state_q <= nxt;
      if (launch) begin
        op_wr_q  <= sel_wr;
        op_reg_q <= sel_reg;
        op_wd_q  <= sel_wd;
        op_gap_q <= poll_gap;
        tout_q   <= 1'b0;
      end else if (poll_busy && last_try) begin
        tout_q <= 1'b1;
      end
      reg_req   <= acc_n;
      reg_we    <= we_n;
      reg_addr  <= addr_n;
      reg_wdata <= data_n;
      done      <= (state_q == ST_FIN);
      err       <= (state_q == ST_FIN) && tout_q;
      if (state_q == ST_FIN)
        rdata <= (!op_wr_q && !tout_q) ? rd_word : '0;
    end
  end

  assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/piac_checker.sv
module piac_checker #(
  parameter int                REG_AW = 8,
  parameter int                WORD_W = 16,
  parameter logic [REG_AW-1:0] A_CMD  = 8'h12,
  parameter logic [REG_AW-1:0] A_STAT = 8'h0A,
  parameter int                RD_BIT = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [WORD_W-1:0] rdata,
  input logic              reg_req,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr,
  input logic [7:0]        reg_wdata,
  input logic              reg_done
);
  localparam logic [7:0] RD_MASK = 8'(1) << RD_BIT;

  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    reg_req && !reg_done |=> reg_req && $stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata));

  p_err_with_done_r8: assert property (@(posedge clk) disable iff (rst)
    err |-> done);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_idle_no_req_r9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !reg_req);

  p_stat_is_read_r4: assert property (@(posedge clk) disable iff (rst)
    reg_req && reg_addr == A_STAT |-> !reg_we);

  p_timeout_zero_r6: assert property (@(posedge clk) disable iff (rst)
    done && err |-> rdata == '0);

  p_cmd_values_r3: assert property (@(posedge clk) disable iff (rst)
    reg_req && reg_we && reg_addr == A_CMD |-> (reg_wdata == RD_MASK || reg_wdata == 8'h00));
endmodule

bind phy_ind_ctrl piac_checker #(
  .REG_AW(REG_AW), .WORD_W(2 * piac_pkg::BYTE_W), .A_CMD(A_CMD), .A_STAT(A_STAT), .RD_BIT(RD_BIT)
) u_piac_checker (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .err(err), .rdata(rdata),
  .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_done(reg_done)
);

// File: tb/phy_ind_ctrl_bench.sv
`timescale 1ns/1ps
module phy_ind_ctrl_bench;
  localparam logic [7:0] A_PHYADR = 8'h14, A_WDL = 8'h16, A_WDH = 8'h17, A_CMD = 8'h12;
  localparam logic [7:0] A_STAT = 8'h0A, A_RDL = 8'h18, A_RDH = 8'h19;
  localparam int MAXP = 15;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst = 1'b1, start = 1'b0, wr = 1'b0;
  logic [4:0]  phy_reg = '0;
  logic [15:0] wdata = '0;
  logic [7:0]  poll_gap = '0;
  logic        busy, done, err;
  logic [15:0] rdata;
  logic        reg_req, reg_we, reg_done;
  logic [7:0]  reg_addr, reg_wdata, reg_rdata;

  phy_ind_ctrl u_phy_ind_ctrl (
    .clk(clk), .rst(rst), .start(start), .wr(wr), .phy_reg(phy_reg), .wdata(wdata),
    .poll_gap(poll_gap), .busy(busy), .done(done), .err(err), .rdata(rdata),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_done(reg_done)
  );

  int checks = 0, fails = 0;
  int lat = 1, nbusy = 0, stat_base = 0;
  logic [7:0] rdl_v = '0, rdh_v = '0;

  // Responder state
  int stat_reads = 0, wait_cnt = 0;
  logic [7:0] cap_addr, cap_wd;
  logic cap_we;

  always @(posedge clk) begin
    if (rst) begin
      reg_done  <= 1'b0;
      reg_rdata <= '0;
      wait_cnt  <= 0;
    end else if (reg_req && !reg_done) begin
      if (wait_cnt == 0) begin
        cap_addr <= reg_addr; cap_we <= reg_we; cap_wd <= reg_wdata;
      end
      if (wait_cnt >= lat - 1) begin
        reg_done <= 1'b1;
        wait_cnt <= 0;
        if (!reg_we && reg_addr == A_STAT) begin
          reg_rdata  <= (stat_reads - stat_base < nbusy) ? 8'hA5 : 8'hA4;
          stat_reads <= stat_reads + 1;
        end else if (!reg_we && reg_addr == A_RDL) reg_rdata <= rdl_v;
        else if (!reg_we && reg_addr == A_RDH)     reg_rdata <= rdh_v;
        else                                       reg_rdata <= 8'h5A;
      end else begin
        wait_cnt <= wait_cnt + 1;
      end
    end else begin
      reg_done <= 1'b0;
    end
  end

  // Monitor (cumulative counters)
  logic [7:0] log_addr [0:2047];
  logic [7:0] log_wd   [0:2047];
  logic       log_we   [0:2047];
  int log_n = 0, lowcnt = 0, donecnt = 0, hold_err = 0;
  logic last_err = 1'b0;
  logic [15:0] last_rdata = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (reg_req && reg_done) begin
        if (log_n < 2048) begin
          log_addr[log_n] = reg_addr; log_wd[log_n] = reg_wdata; log_we[log_n] = reg_we;
        end
        log_n = log_n + 1;
        if (reg_addr != cap_addr || reg_we != cap_we || (reg_we && reg_wdata != cap_wd))
          hold_err = hold_err + 1;
      end
      if (busy && !reg_req) lowcnt = lowcnt + 1;
      if (done) begin
        donecnt = donecnt + 1;
        last_err = err;
        last_rdata = rdata;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_entry(input int k, input bit we_e, input logic [7:0] a_e,
                           input logic [7:0] d_e, input string req);
    bit ok;
    ok = (k < 2048) && log_we[k] == we_e && log_addr[k] == a_e && (!we_e || log_wd[k] == d_e);
    chk(ok, req, $sformatf("access %0d we/addr/data", k), (k < 2048) ?
        {log_we[k], log_addr[k], log_wd[k]} : 0, {we_e, a_e, d_e});
  endtask

  task automatic run_op(input bit w, input logic [4:0] pa, input logic [15:0] wd,
                        input int nb, input int gap, input int l, input bit poke);
    int b_log, b_low, b_done, b_hold, polls, k, t, nexp;
    bit tout;
    nbusy = nb; lat = l;
    rdl_v = wd[7:0] ^ 8'h3C; rdh_v = wd[15:8] ^ 8'hC3;
    stat_base = stat_reads;
    b_log = log_n; b_low = lowcnt; b_done = donecnt; b_hold = hold_err;
    @(negedge clk);
    start = 1'b1; wr = w; phy_reg = pa; wdata = wd; poll_gap = 8'(gap);
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R9: a second start mid-operation with different fields
      repeat (3) @(negedge clk);
      start = 1'b1; wr = ~w; phy_reg = ~pa; wdata = ~wd; poll_gap = 8'(gap + 7);
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (donecnt == b_done && t < 5000) begin @(negedge clk); t++; end
    chk(t < 5000, "R8", "operation completes", t, 0);
    @(negedge clk);
    @(negedge clk);
    polls = (nb >= MAXP) ? MAXP : nb + 1;
    tout  = (nb >= MAXP);
    nexp  = w ? 3 + polls : 2 + polls + (tout ? 0 : 3);
    chk(log_n - b_log == nexp, poke ? "R9" : (w ? "R2" : "R3"), "access count", log_n - b_log, nexp);
    if (log_n - b_log == nexp) begin
      k = b_log;
      chk_entry(k, 1, A_PHYADR, {3'b000, pa}, w ? "R2" : "R3"); k++;
      if (w) begin
        chk_entry(k, 1, A_WDL, wd[7:0], "R2");  k++;
        chk_entry(k, 1, A_WDH, wd[15:8], "R2"); k++;
      end else begin
        chk_entry(k, 1, A_CMD, 8'h01, "R3"); k++;
      end
      for (int i = 0; i < polls; i++) begin
        chk_entry(k, 0, A_STAT, 8'h00, tout ? "R6" : "R4"); k++;
      end
      if (!w && !tout) begin
        chk_entry(k, 1, A_CMD, 8'h00, "R7"); k++;
        chk_entry(k, 0, A_RDL, 8'h00, "R7"); k++;
        chk_entry(k, 0, A_RDH, 8'h00, "R7"); k++;
      end
    end
    chk(donecnt - b_done == 1, "R8", "done pulse cycles", donecnt - b_done, 1);
    chk(last_err == tout, "R8", "err with done", last_err, tout);
    chk(last_rdata == ((w || tout) ? 16'h0 : {rdh_v, rdl_v}), tout ? "R6" : "R7", "rdata",
        last_rdata, (w || tout) ? 16'h0 : {rdh_v, rdl_v});
    chk(rdata == last_rdata, "R7", "rdata held after done", rdata, last_rdata);
    chk(lowcnt - b_low == (polls - 1) * (gap + 1) + 1, "R5", "request-low cycles",
        lowcnt - b_low, (polls - 1) * (gap + 1) + 1);
    chk(hold_err == b_hold, "R10", "request held until done", hold_err - b_hold, 0);
    chk(!busy && !reg_req, "R6", "idle after completion", {busy, reg_req}, 0);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", fails, checks + 1);
    $finish;
  end

  initial begin
    int nbl [6] = '{0, 1, 3, 14, 15, 20};
    int gpl [3] = '{0, 2, 5};
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !err && !reg_req && rdata == 16'h0, "R1", "reset state",
        {busy, done, err, reg_req}, 0);
    for (int l = 1; l <= 3; l += 2)
      for (int w = 0; w < 2; w++)
        for (int bi = 0; bi < 6; bi++)
          for (int gi = 0; gi < 3; gi++) begin
            logic [4:0]  pa;
            logic [15:0] wd;
            pa = 5'((bi * 7 + gi * 3 + w * 11 + l) % 32);
            wd = 16'(16'hA55A ^ (bi * 16'h1357) ^ (gi * 16'h0F21) ^ (l * 16'h4004));
            run_op(w[0], pa, wd, nbl[bi], gpl[gi], l, gi == 1);
          end
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end
endmodule